// File: doc/BRIEF.md
# Timer Compare Output Unit

This block is one compare channel that sits beside two free-running 16-bit timers. It holds a 16-bit compare value and checks it on every clock against the count of the timer picked by a select input. When the two first become equal, the channel changes an output latch according to a 4-bit mode field and sets a sticky interrupt flag. The mode field can drive the latch high, drive it low or toggle it. It also has a software-interrupt mode that sets only the flag, and some encodings that do nothing.

The latch reaches the pin only while the direction bit marks the pin as an output. The pin is otherwise reported as not driven. Writing a mode of zero returns the latch to its low default. Software clears the flag with a write-one-to-clear strobe. An interrupt request leaves the block only when the flag and a separate enable are both set. The timers are outside the block, and their counts arrive as plain inputs.

Top module: `tcmp_unit`

## Requirements
- R1: A match needs all 16 bits of the selected timer count to equal the compare value; a count that differs only in bit 15 does not match.
- R2: With `tsel` = 0 the compare uses `timer_a`, and with `tsel` = 1 it uses `timer_b`; the unselected timer never causes a match.
- R3: On a match the latch becomes 1 in mode 4'b1000, 0 in mode 4'b1001, and its inverse in mode 4'b0010; the change is visible after the same clock edge that sees the equal count.
- R4: In mode 4'b1010 a match sets the flag and leaves the latch unchanged.
- R5: Any mode other than 4'b1000, 4'b1001, 4'b0010 and 4'b1010 never sets the flag and never changes the latch on a match.
- R6: While the registered mode is 4'b0000 the latch is forced to 0 at every clock edge.
- R7: A match acts once, at the first edge where the count equals the compare value; further edges with the count held equal do nothing.
- R8: The flag is set by a match in the modes 4'b1000, 4'b1001, 4'b0010 and 4'b1010 and stays set until `flag_clr` is 1 at an edge; a clear and a match at the same edge leave it set.
- R9: `irq` is 1 exactly when the flag is set and `irq_en` is 1.
- R10: `pin_oe` follows `out_en`; `pin_val` shows the latch while `out_en` is 1 and is 0 otherwise, and the latch keeps its value while the pin is not driven.
- R11: `cmp_val`, `tsel` and `mode` are sampled at a clock edge and govern the compare from the following edge; after reset the latch, flag and sampled settings are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timer_a | input | 16 | Count of the first timer |
| timer_b | input | 16 | Count of the second timer |
| cmp_val | input | 16 | Compare value |
| tsel | input | 1 | Timer select: 0 first timer, 1 second timer |
| mode | input | 4 | Compare action field |
| out_en | input | 1 | Direction bit: 1 drives the pin |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| pin_val | output | 1 | Value on the pin while driven, 0 otherwise |
| pin_oe | output | 1 | Pin output enable |
| flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input changes only between clock edges and is stable at the edge. They also treat `flag_clr` as a strobe that may coincide with a match. They do not expect the timer counts to advance in any order, so the bench stalls counts, jumps them and repeats values at will. The stimulus drives every input a fixed delay after the rising edge, which keeps each input stable across the next edge. The reference model reads only those inputs and follows the sampled-settings latency described in R11.

// File: rtl/tcmp_pkg.sv
// Package: shared mode encodings and helpers for the timer compare unit.
// Assumes the mode field is 4 bits wide.
package tcmp_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF    = 4'b0000,
        MODE_TOGGLE = 4'b0010,
        MODE_SET    = 4'b1000,
        MODE_CLR    = 4'b1001,
        MODE_SWINT  = 4'b1010
    } tcmp_mode_e;

    // True for encodings whose match sets the flag.
    function automatic logic mode_active(input logic [MODE_W-1:0] m);
        return (m == MODE_TOGGLE) || (m == MODE_SET) ||
               (m == MODE_CLR) || (m == MODE_SWINT);
    endfunction

endpackage

// File: rtl/tcmp_cfg_reg.sv
// Module: registers the compare value, timer select and mode so that a
// change seen at one edge governs comparisons from the next edge on.
// Assumes inputs are stable around the clock edge.
module tcmp_cfg_reg #(
    parameter int CMP_W = 16,
    parameter int SEL_W = 1,
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMP_W-1:0]  cmp_in,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [MODE_W-1:0] mode_in,
    output logic [CMP_W-1:0]  cmp_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic [MODE_W-1:0] mode_q
);

    // Capture the settings every cycle; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            sel_q  <= '0;
            mode_q <= '0;
        end else begin
            cmp_q  <= cmp_in;
            sel_q  <= sel_in;
            mode_q <= mode_in;
        end
    end

endmodule

// File: rtl/tcmp_match_det.sv
// Module: compares each timer source against the compare value, selects one
// result and reports a one-cycle hit on its rising edge only.
// Assumes sel is below N_SRC.
module tcmp_match_det #(
    parameter int CMP_W = 16,
    parameter int N_SRC = 2,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_SRC-1:0][CMP_W-1:0] src,
    input  logic [CMP_W-1:0]            cmp,
    input  logic [SEL_W-1:0]            sel,
    output logic                        hit
);

    logic [N_SRC-1:0] eq_vec;
    logic             eq_sel;
    logic             eq_prev;

    // One full-width equality comparator per timer source.
    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_cmp
            assign eq_vec[i] = (src[i] == cmp);
        end
    endgenerate

    // Pick the comparator of the selected source.
    always_comb begin
        eq_sel = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel == SEL_W'(i)) eq_sel = eq_vec[i];
        end
    end

    // Remember last cycle's equality to qualify the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_prev <= 1'b0;
        else        eq_prev <= eq_sel;
    end

    assign hit = eq_sel & ~eq_prev;

endmodule

// File: rtl/tcmp_out_ctl.sv
// Module: holds the output latch and the sticky flag and applies the mode
// action on a hit. Assumes hit is a single-cycle pulse.
module tcmp_out_ctl
    import tcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [MODE_W-1:0] mode,
    input  logic              flag_clr,
    output logic              latch,
    output logic              flag
);

    // Latch update: forced low in mode zero, otherwise driven by the action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch <= 1'b0;
        end else if (mode == MODE_OFF) begin
            latch <= 1'b0;
        end else if (hit) begin
            case (mode)
                MODE_SET:    latch <= 1'b1;
                MODE_CLR:    latch <= 1'b0;
                MODE_TOGGLE: latch <= ~latch;
                default:     latch <= latch;
            endcase
        end
    end

    // Flag: set by an active hit, which wins over a clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                         flag <= 1'b0;
        else if (hit && mode_active(mode))  flag <= 1'b1;
        else if (flag_clr)                  flag <= 1'b0;
    end

endmodule

// File: rtl/tcmp_unit.sv
// Module: top of the timer compare channel. Registers the settings, detects
// the first equal cycle against the selected timer, applies the mode action
// and gates the pin and interrupt. Assumes synchronous timer inputs.
module tcmp_unit
    import tcmp_pkg::*;
#(
    parameter int CMP_W = 16,
    localparam int N_SRC = 2,
    localparam int SEL_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMP_W-1:0]  timer_a,
    input  logic [CMP_W-1:0]  timer_b,
    input  logic [CMP_W-1:0]  cmp_val,
    input  logic              tsel,
    input  logic [MODE_W-1:0] mode,
    input  logic              out_en,
    input  logic              irq_en,
    input  logic              flag_clr,
    output logic              pin_val,
    output logic              pin_oe,
    output logic              flag,
    output logic              irq
);

    logic [CMP_W-1:0]            cmp_q;
    logic [SEL_W-1:0]            sel_q;
    logic [MODE_W-1:0]           mode_q;
    logic [N_SRC-1:0][CMP_W-1:0] srcs;
    logic                        hit;
    logic                        latch_q;
    logic                        flag_q;

    assign srcs[0] = timer_a;
    assign srcs[1] = timer_b;

    tcmp_cfg_reg #(.CMP_W(CMP_W), .SEL_W(SEL_W), .MODE_W(MODE_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cmp_in(cmp_val), .sel_in(tsel), .mode_in(mode),
        .cmp_q(cmp_q), .sel_q(sel_q), .mode_q(mode_q)
    );

    tcmp_match_det #(.CMP_W(CMP_W), .N_SRC(N_SRC)) u_det (
        .clk(clk), .rst_n(rst_n),
        .src(srcs), .cmp(cmp_q), .sel(sel_q), .hit(hit)
    );

    tcmp_out_ctl u_out (
        .clk(clk), .rst_n(rst_n),
        .hit(hit), .mode(mode_q), .flag_clr(flag_clr),
        .latch(latch_q), .flag(flag_q)
    );

    // Pin and interrupt gating.
    assign pin_oe  = out_en;
    assign pin_val = out_en & latch_q;
    assign flag    = flag_q;
    assign irq     = flag_q & irq_en;

endmodule

// File: rtl/tcmp_unit_chk.sv
// Checker: temporal properties of the compare channel, bound to the top.
module tcmp_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] mode_q,
    input logic       hit,
    input logic       latch_q,
    input logic       flag,
    input logic       flag_clr,
    input logic       irq,
    input logic       irq_en
);

    // R8: the flag holds without a clear strobe.
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    // R8: a clear with no hit empties the flag.
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !hit) |=> !flag);

    // R6: mode zero leaves the latch low after the edge.
    p_zero_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 4'b0000) |=> !latch_q);

    // R4: software-interrupt mode never moves the latch.
    p_swint_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 4'b1010) |=> $stable(latch_q));

    // R5: no hit means the flag cannot rise.
    p_no_hit_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !$rose(flag));

    // R9: a disabled interrupt never requests.
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

endmodule

bind tcmp_unit tcmp_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .hit(hit),
    .latch_q(latch_q), .flag(flag), .flag_clr(flag_clr),
    .irq(irq), .irq_en(irq_en)
);

// File: tb/tcmp_unit_bench.sv
module tcmp_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_a = '0, timer_b = '0, cmp_val = '0;
    logic        tsel = 1'b0;
    logic [3:0]  mode = '0;
    logic        out_en = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
    logic        pin_val, pin_oe, flag, irq;

    int total = 0;
    int fails = 0;
    int cycles = 0;
    bit started = 0;

    // reference model state
    logic [15:0] m_cmp = '0;
    logic        m_sel = 0;
    logic [3:0]  m_mode = '0;
    logic        m_prev = 0, m_latch = 0, m_flag = 0;

    always #5 clk = ~clk;

    tcmp_unit u_tcmp_unit (
        .clk(clk), .rst_n(rst_n), .timer_a(timer_a), .timer_b(timer_b),
        .cmp_val(cmp_val), .tsel(tsel), .mode(mode), .out_en(out_en),
        .irq_en(irq_en), .flag_clr(flag_clr), .pin_val(pin_val),
        .pin_oe(pin_oe), .flag(flag), .irq(irq)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    // behavioural reference updated at every edge from the driven inputs
    always @(posedge clk) begin
        logic eq, hit, act;
        cycles++;
        started = 1;
        if (!rst_n) begin
            m_cmp = '0; m_sel = 0; m_mode = '0;
            m_prev = 0; m_latch = 0; m_flag = 0;
        end else begin
            eq  = ((m_sel ? timer_b : timer_a) == m_cmp);
            hit = eq && !m_prev;
            act = (m_mode == 4'b1000) || (m_mode == 4'b1001) ||
                  (m_mode == 4'b0010) || (m_mode == 4'b1010);
            if (m_mode == 4'b0000) m_latch = 0;
            else if (hit) begin
                if (m_mode == 4'b1000) m_latch = 1;
                else if (m_mode == 4'b1001) m_latch = 0;
                else if (m_mode == 4'b0010) m_latch = ~m_latch;
            end
            if (hit && act) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            m_prev = eq;
            m_cmp = cmp_val; m_sel = tsel; m_mode = mode;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            chk("R3 pin_val", pin_val, out_en & m_latch);
            chk("R8 flag", flag, m_flag);
            chk("R9 irq", irq, m_flag & irq_en);
            chk("R10 pin_oe", pin_oe, out_en);
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        out_en = 1;
        step(3);
        chk("R11 reset latch", pin_val, 1'b0);
        chk("R11 reset flag", flag, 1'b0);
        rst_n = 1;

        // R3 set-high on first equal count
        cmp_val = 16'h1234; mode = 4'b1000; tsel = 0; timer_a = 16'h1230;
        step(2);
        timer_a = 16'h1233; step(1);
        chk("R3 no match yet", flag, 1'b0);
        timer_a = 16'h1234; step(1);
        chk("R3 set latch", pin_val, 1'b1);
        chk("R8 flag set", flag, 1'b1);

        // R7 stalled equal count does not re-fire
        mode = 4'b1001; step(3);
        chk("R7 held equal no action", pin_val, 1'b1);

        // R8 clear
        flag_clr = 1; step(1); flag_clr = 0;
        chk("R8 cleared", flag, 1'b0);

        // R3 clear-low
        timer_a = 16'h1235; step(1);
        timer_a = 16'h1234; step(1);
        chk("R3 clear latch", pin_val, 1'b0);

        // R3 toggle
        mode = 4'b0010; step(1);
        timer_a = 16'h0000; step(1);
        timer_a = 16'h1234; step(1);
        chk("R3 toggle up", pin_val, 1'b1);

        // R8 clear and match together
        timer_a = 16'h0000; step(1);
        flag_clr = 1; timer_a = 16'h1234; step(1); flag_clr = 0;
        chk("R8 set wins", flag, 1'b1);
        chk("R3 toggle down", pin_val, 1'b0);

        // R9 interrupt gating
        #1 chk("R9 irq off", irq, 1'b0);
        irq_en = 1; #1 chk("R9 irq on", irq, 1'b1);
        flag_clr = 1; step(1); flag_clr = 0;
        chk("R9 irq drops", irq, 1'b0);

        // R10 pin not driven keeps latch
        out_en = 0;
        timer_a = 16'h0000; step(1);
        timer_a = 16'h1234; step(1);
        chk("R10 pin_val low", pin_val, 1'b0);
        chk("R10 pin_oe low", pin_oe, 1'b0);
        out_en = 1; #1 chk("R10 latch kept", pin_val, 1'b1);
        flag_clr = 1; step(1); flag_clr = 0;

        // R2 timer select
        tsel = 1; timer_b = 16'h0000; timer_a = 16'h0000; step(2);
        timer_a = 16'h1234; step(1);
        chk("R2 unselected timer", flag, 1'b0);
        timer_b = 16'h1234; step(1);
        chk("R2 selected timer", flag, 1'b1);

        // R1 full width
        flag_clr = 1; timer_b = 16'h9234; step(1); flag_clr = 0;
        step(1);
        chk("R1 bit15 differs", flag, 1'b0);
        timer_b = 16'h1234; step(1);
        chk("R1 exact match", flag, 1'b1);

        // R4 software-interrupt mode
        mode = 4'b1010; flag_clr = 1; step(1); flag_clr = 0;
        timer_b = 16'h0000; step(1);
        timer_b = 16'h1234; step(1);
        chk("R4 flag set", flag, 1'b1);
        chk("R4 latch kept", pin_val, 1'b1);

        // R5 inactive mode
        mode = 4'b0111; flag_clr = 1; step(1); flag_clr = 0;
        timer_b = 16'h0000; step(1);
        timer_b = 16'h1234; step(1);
        chk("R5 no flag", flag, 1'b0);
        chk("R5 latch kept", pin_val, 1'b1);

        // R6 zero mode forces low
        mode = 4'b0000; step(1);
        chk("R6 not yet", pin_val, 1'b1);
        step(1);
        chk("R6 forced low", pin_val, 1'b0);

        // R11 settings latency
        mode = 4'b1000; cmp_val = 16'h0050; timer_b = 16'h0050; step(1);
        chk("R11 old settings", flag, 1'b0);
        step(1);
        chk("R11 new settings", flag, 1'b1);
        chk("R11 new mode", pin_val, 1'b1);

        // counting run with timer_b sweeping past the compare value
        mode = 4'b0010; flag_clr = 1; step(1); flag_clr = 0;
        for (int k = 0; k < 300; k++) begin
            timer_b = 16'(k);
            flag_clr = (k % 7 == 0);
            step(1);
        end
        flag_clr = 0;
        step(2);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule